// File: doc/BRIEF.md
# Inter-processor interrupt destination matcher

This block takes an interrupt command, written as a low and a high 32-bit word, and works out which of N processors it is aimed at. Every processor presents a physical ID byte, a logical ID byte and a two-bit destination-format setting. The block turns these into a per-processor hit vector. A shorthand code can override addressing. Addressing can be physical, with a broadcast ID, or logical, in flat or cluster form.

The high word is written first and only its top byte, the destination, is kept. Writing the low word triggers the decode. One cycle later the hit vector is presented together with a valid strobe, and the vector, delivery mode, level and trigger fields of the command are shown beside it. In lowest-priority delivery mode the block narrows the matches to a single enabled processor. It chooses that processor in round-robin order and remembers where the last search ended.

Top module: `ipi_dest_match`

## Requirements
- R1: While `hit_valid` is high, `hit_vector` shows low-word bits 7:0, `hit_mode` bits 10:8, `hit_level` bit 14 and `hit_trig` bit 15 of the command that caused it.
- R2: `cmd_word` returns the last low word written, with bit 12 always read as 0 and all other bits kept.
- R3: With shorthand (low bits 19:18) equal to 0 and destination mode (bit 11) equal to 0, processor i hits when the destination byte (high-word bits 31:24) is 0xFF or equals its physical ID.
- R4: With shorthand 0, bit 11 set and format code 2'b00 (flat), processor i hits when its logical ID AND the destination is nonzero.
- R5: With shorthand 0, bit 11 set and format code 2'b01 (cluster), processor i hits when the upper nibbles of its logical ID and the destination are equal and the AND of the lower nibbles is nonzero.
- R6: In logical mode, a processor whose format code is 2'b10 or 2'b11 never hits.
- R7: Shorthand 1 hits only the processor given by `src_idx`, whatever the destination.
- R8: Shorthand 2 hits every processor.
- R9: Shorthand 3 hits every processor except `src_idx`.
- R10: With delivery mode 3'b001 (lowest priority), the hit vector holds exactly one bit. That bit is the first processor that both matched and has `tgt_en` set, scanning upward from the index after the last choice and wrapping at N. The choice becomes the new start point. After reset the scan starts at index 0.
- R11: In lowest-priority mode with no enabled matching processor, the hit vector is all zeros and the start point is left unchanged.
- R12: `hit_valid` is high for exactly the one cycle after a low-word write, and `hit_vec` is zero whenever `hit_valid` is low. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lo_wr | input | 1 | Low command word write strobe; triggers a decode |
| cmd_lo_wdata | input | 32 | Low command word |
| cmd_hi_wr | input | 1 | High command word write strobe |
| cmd_hi_wdata | input | 32 | High command word; bits 31:24 are the destination |
| src_idx | input | IDX_W | Index of the issuing processor |
| phys_ids | input | 8*N | Physical ID of processor i in bits 8i+7:8i |
| log_ids | input | 8*N | Logical ID of processor i in bits 8i+7:8i |
| dst_fmt | input | 2*N | Format code of processor i in bits 2i+1:2i |
| tgt_en | input | N | Processor enabled for lowest-priority choice |
| hit_valid | output | 1 | Result strobe |
| hit_vec | output | N | Per-processor hit vector |
| hit_vector | output | 8 | Interrupt vector of the command |
| hit_mode | output | 3 | Delivery mode of the command |
| hit_level | output | 1 | Assert level of the command |
| hit_trig | output | 1 | Trigger mode of the command |
| cmd_word | output | 32 | Stored low command word |

## Verification
The only hidden state is the round-robin start point and the stored destination byte. If the start point is wrong, the next lowest-priority command goes to the wrong processor, one cycle after its write. The bench therefore issues chains of lowest-priority commands that include disabled processors, a shorthand-restricted set and an empty set. Each choice then depends on the one before, and on whether an empty search left the pointer alone. A destination byte that was stored badly shows up in the very next physical or logical decode.

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_lo_wr,
  input  logic [31:0]      cmd_lo_wdata,
  input  logic             cmd_hi_wr,
  input  logic [31:0]      cmd_hi_wdata,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [8*N-1:0]   phys_ids,
  input  logic [8*N-1:0]   log_ids,
  input  logic [2*N-1:0]   dst_fmt,
  input  logic [N-1:0]     tgt_en,
  output logic             hit_valid,
  output logic [N-1:0]     hit_vec,
  output logic [7:0]       hit_vector,
  output logic [2:0]       hit_mode,
  output logic             hit_level,
  output logic             hit_trig,
  output logic [31:0]      cmd_word
);

  localparam logic [2:0] MODE_LOWEST = 3'b001;
  localparam logic [1:0] FMT_FLAT    = 2'b00;
  localparam logic [1:0] FMT_CLUSTER = 2'b01;

  logic [7:0]       dest_q;
  logic [31:0]      word_q;
  logic             valid_q;
  logic [N-1:0]     vec_q;
  logic [IDX_W-1:0] rr_ptr;

  logic [1:0] shorthand;
  logic       logical;
  logic       lowest;
  assign shorthand = cmd_lo_wdata[19:18];
  assign logical   = cmd_lo_wdata[11];
  assign lowest    = (cmd_lo_wdata[10:8] == MODE_LOWEST);

  logic [N-1:0] match;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [7:0] pid, lid;
      logic [1:0] fmt;
      pid = phys_ids[8*i +: 8];
      lid = log_ids[8*i +: 8];
      fmt = dst_fmt[2*i +: 2];
      unique case (shorthand)
        2'd0: begin
          if (!logical)
            match[i] = (dest_q == 8'hFF) || (dest_q == pid);
          else if (fmt == FMT_FLAT)
            match[i] = |(lid & dest_q);
          else if (fmt == FMT_CLUSTER)
            match[i] = (lid[7:4] == dest_q[7:4]) && (|(lid[3:0] & dest_q[3:0]));
          else
            match[i] = 1'b0;
        end
        2'd1:    match[i] = (src_idx == IDX_W'(i));
        2'd2:    match[i] = 1'b1;
        default: match[i] = (src_idx != IDX_W'(i));
      endcase
    end
  end

  logic [N-1:0]     cand, pick;
  logic [IDX_W-1:0] ptr_nxt;
  logic             found;
  assign cand = match & tgt_en;

  always_comb begin
    found   = 1'b0;
    pick    = '0;
    ptr_nxt = rr_ptr;
    for (int k = 1; k <= N; k++) begin
      int s;
      s = int'(rr_ptr) + k;
      if (s >= N) s = s - N;
      if (!found && cand[s]) begin
        found   = 1'b1;
        pick[s] = 1'b1;
        ptr_nxt = IDX_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      vec_q   <= '0;
      rr_ptr  <= IDX_W'(N - 1);
    end else begin
      if (cmd_hi_wr) dest_q <= cmd_hi_wdata[31:24];
      valid_q <= cmd_lo_wr;
      vec_q   <= '0;
      if (cmd_lo_wr) begin
        word_q <= cmd_lo_wdata & ~32'h0000_1000;
        vec_q  <= lowest ? pick : match;
        if (lowest) rr_ptr <= ptr_nxt;
      end
    end
  end

  assign hit_valid  = valid_q;
  assign hit_vec    = vec_q;
  assign hit_vector = word_q[7:0];
  assign hit_mode   = word_q[10:8];
  assign hit_level  = word_q[14];
  assign hit_trig   = word_q[15];
  assign cmd_word   = word_q;

  // R10
  lowest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_mode == MODE_LOWEST) |-> $onehot0(hit_vec));

  // R10
  lowest_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_lo_wr) && hit_mode == MODE_LOWEST) |-> ((hit_vec & ~$past(tgt_en)) == '0));

  // R11
  lowest_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_mode == MODE_LOWEST && hit_vec == '0) |-> $stable(rr_ptr));

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> (hit_vec == '0));

  // R8
  all_incl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && cmd_word[19:18] == 2'd2 && hit_mode != MODE_LOWEST) |-> (&hit_vec));

  // R2
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lo_wr |=> (cmd_word[12] == 1'b0 && cmd_word[11:0] == $past(cmd_lo_wdata[11:0])));

endmodule

// File: tb/ipi_dest_match_tb.sv
module ipi_dest_match_tb;
  localparam int N = 4;
  localparam int IDX_W = 2;

  logic clk = 0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             cmd_lo_wr, cmd_hi_wr;
  logic [31:0]      cmd_lo_wdata, cmd_hi_wdata;
  logic [IDX_W-1:0] src_idx;
  logic [8*N-1:0]   phys_ids, log_ids;
  logic [2*N-1:0]   dst_fmt;
  logic [N-1:0]     tgt_en;
  logic             hit_valid, hit_level, hit_trig;
  logic [N-1:0]     hit_vec;
  logic [7:0]       hit_vector;
  logic [2:0]       hit_mode;
  logic [31:0]      cmd_word;

  ipi_dest_match #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_lo_wr(cmd_lo_wr), .cmd_lo_wdata(cmd_lo_wdata),
    .cmd_hi_wr(cmd_hi_wr), .cmd_hi_wdata(cmd_hi_wdata),
    .src_idx(src_idx), .phys_ids(phys_ids), .log_ids(log_ids),
    .dst_fmt(dst_fmt), .tgt_en(tgt_en),
    .hit_valid(hit_valid), .hit_vec(hit_vec), .hit_vector(hit_vector),
    .hit_mode(hit_mode), .hit_level(hit_level), .hit_trig(hit_trig),
    .cmd_word(cmd_word)
  );

  typedef struct {
    logic [N-1:0] vec;
    logic [31:0]  lo;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  int m_ptr = N - 1;
  logic [7:0] m_dest = 0;
  logic [7:0] pid [N];
  logic [7:0] lid [N];
  logic [1:0] fmt [N];
  logic [N-1:0] en;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      phys_ids[8*i +: 8] = pid[i];
      log_ids[8*i +: 8]  = lid[i];
      dst_fmt[2*i +: 2]  = fmt[i];
    end
    tgt_en = en;
  end

  function automatic logic [N-1:0] model(logic [31:0] lo, int src);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) begin
      case (lo[19:18])
        2'd0: if (!lo[11]) m[i] = (m_dest == 8'hFF) || (m_dest == pid[i]);
              else if (fmt[i] == 2'b00) m[i] = (lid[i] & m_dest) != 0;
              else if (fmt[i] == 2'b01) m[i] = (lid[i][7:4] == m_dest[7:4]) && ((lid[i][3:0] & m_dest[3:0]) != 0);
              else m[i] = 0;
        2'd1: m[i] = (i == src);
        2'd2: m[i] = 1;
        default: m[i] = (i != src);
      endcase
    end
    return m;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_dest(logic [7:0] d);
    @(negedge clk);
    cmd_hi_wr = 1; cmd_hi_wdata = {d, 24'h00ABCD};
    m_dest = d;
    @(negedge clk);
    cmd_hi_wr = 0;
  endtask

  task automatic send(logic [31:0] lo, int src, string tag);
    item_t it;
    logic [N-1:0] m;
    @(negedge clk);
    m = model(lo, src);
    if (lo[10:8] == 3'b001) begin
      logic [N-1:0] p;
      p = '0;
      for (int k = 1; k <= N; k++) begin
        int s;
        s = (m_ptr + k) % N;
        if (p == 0 && m[s] && en[s]) begin
          p[s] = 1;
          m_ptr = s;
        end
      end
      m = p;
    end
    it.vec = m; it.lo = lo; it.tag = tag;
    q.push_back(it);
    cmd_lo_wr = 1; cmd_lo_wdata = lo; src_idx = IDX_W'(src);
    @(negedge clk);
    cmd_lo_wr = 0;
    check(cmd_word == (lo & ~32'h1000), "R2", "cmd_word", cmd_word, lo & ~32'h1000);
    @(negedge clk);
    check(!hit_valid && hit_vec == 0, "R12", "idle after strobe", {hit_valid, 27'b0, hit_vec}, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && hit_valid) begin
      if (q.size() == 0) begin
        check(0, "R12", "unexpected strobe", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(hit_vec == it.vec, it.tag, "hit_vec", 32'(hit_vec), 32'(it.vec));
        check({hit_trig, hit_level, hit_mode, hit_vector} == {it.lo[15], it.lo[14], it.lo[10:8], it.lo[7:0]},
              "R1", "fields", {19'b0, hit_trig, hit_level, hit_mode, hit_vector},
              {19'b0, it.lo[15], it.lo[14], it.lo[10:8], it.lo[7:0]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_lo_wr = 0; cmd_hi_wr = 0; cmd_lo_wdata = 0; cmd_hi_wdata = 0; src_idx = 0;
    for (int i = 0; i < N; i++) begin
      pid[i] = 8'h10 + 8'(i); lid[i] = 8'(1 << i); fmt[i] = 2'b00;
    end
    en = '1;
    repeat (3) @(negedge clk);
    check(!hit_valid && hit_vec == 0 && cmd_word == 0, "R12", "reset state", cmd_word, 0);
    rst_n = 1;

    set_dest(8'h12); send(32'h0000_0031, 0, "R3");
    set_dest(8'hFF); send(32'h0000_0032, 0, "R3");
    set_dest(8'h55); send(32'h0000_0033, 0, "R3");

    set_dest(8'h05); send(32'h0000_D845, 0, "R4");
    set_dest(8'h0C); send(32'h0000_0846, 1, "R4");

    lid[0] = 8'h21; lid[1] = 8'h22; lid[2] = 8'h31; lid[3] = 8'h23;
    for (int i = 0; i < N; i++) fmt[i] = 2'b01;
    set_dest(8'h23); send(32'h0000_0850, 0, "R5");
    set_dest(8'h31); send(32'h0000_0851, 0, "R5");

    fmt[1] = 2'b10; fmt[3] = 2'b11;
    set_dest(8'h23); send(32'h0000_0852, 0, "R6");

    set_dest(8'h55);
    send(32'h0004_0060, 2, "R7");
    send(32'h0008_0061, 0, "R8");
    send(32'h000C_0062, 1, "R9");

    set_dest(8'hFF);
    send(32'h0000_0170, 0, "R10");
    send(32'h0000_0171, 0, "R10");
    send(32'h0000_0172, 0, "R10");
    en = 4'b0111;
    send(32'h0000_0173, 0, "R10");
    en = '1;
    send(32'h000C_0174, 1, "R10");
    en = '0;
    send(32'h0000_0175, 0, "R11");
    en = '1;
    send(32'h0000_0176, 0, "R11");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R12", "missing strobes", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule